// File: doc/BRIEF.md
# Interrupt Source Coalescing State Bank

This block keeps a two-bit coalescing state for each of a bank of message-style interrupt sources. The bit weighted 2 (P) marks a source whose event has gone downstream and still waits for its end-of-interrupt. The bit weighted 1 (Q) records that another event arrived while P was set. Together they make sure that a source sits in a downstream queue no more than once at a time. When an event is let through, the block raises a one-cycle notification that carries the source number.

Events come from a hardware trigger port or from stores into a memory-mapped window. Each source owns one page of `2^PAGE_SHIFT` bytes in that window. In the management view, loads at fixed offsets perform end-of-interrupt, read the state, or force it to a chosen value, and every load returns the state as it was before the access. Per source there are three configuration inputs. One marks level-sensitive sources, which also track an asserted bit. One enables management stores. One turns off coalescing for that source.

Per-source states: `PQ_IDLE` (00), `PQ_PEND` (10), `PQ_QUEUED` (11), `PQ_OFF` (01). Named transitions:
- Trigger: IDLE→PEND, which forwards. PEND→QUEUED. QUEUED→QUEUED. OFF→OFF, where the event is dropped.
- End-of-interrupt: PEND→IDLE. OFF→IDLE. QUEUED→PEND, which forwards. IDLE→IDLE.
- Level re-arm: after an end-of-interrupt that lands in IDLE, a level source whose asserted bit is set goes on to PEND and forwards.
- Force: any state → the value encoded in the offset.

Top module: `pqe_bank`

## Requirements
- R1: After reset every source holds the state `RESET_PQ` (default 00) with its asserted bit clear, `rsp_valid` and `notify_valid` are 0, and `trig_ready` is 1 while `mmio_valid` is 0.
- R2: A trigger on a source with coalescing enabled moves it 00→10 with a notification, 10→11 with none, 11→11 with none, and 01→01, dropping the event.
- R3: An end-of-interrupt moves 10→00 and 01→00 without a notification, 11→10 with a notification, and leaves 00 unchanged.
- R4: In the management view, the load offset field `addr[11:10]` decodes as follows: 00 performs end-of-interrupt, 01 and 10 read the state without changing it, and 11 forces the state to `addr[9:8]` (so 0xC00/0xD00/0xE00/0xF00 give 00/01/10/11). Every load gives `rsp_valid` one cycle later, with `rsp_data[1:0]` equal to the state before the access and all other bits 0.
- R5: A management store at offset field 01 (0x400) performs end-of-interrupt, and one at field 10 (0x800) injects a trigger. Both are ignored when `store_eoi_en[src]` is 0. Stores never produce a response.
- R6: The source number is `addr >> PAGE_SHIFT`. When PAGE_SHIFT is 13 or 17, `addr[PAGE_SHIFT-1]` selects the trigger page (0) or the management page (1). Any store to the trigger page triggers, whatever the store enable. A load from the trigger page returns the state and leaves it unchanged.
- R7: `trig_ready` is `!mmio_valid`. A hardware trigger offered while `mmio_valid` is 1 is ignored.
- R8: When `pq_chk_dis[src]` is 1, every trigger on that source forwards a notification and leaves its state unchanged.
- R9: For a source with `lvl_map[src]` = 1, a hardware trigger with `trig_level` = 1 sets the asserted bit and then applies the trigger, and one with `trig_level` = 0 clears the bit and does nothing else. An end-of-interrupt that would end in 00 while the bit is set ends in 10 instead and forwards a notification. On other sources `trig_level` = 0 has no effect.
- R10: `notify_valid` pulses one cycle after the accepting edge, with `notify_src` naming the source. At most one notification is raised per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_map | input | N_SRC | Per-source level-sensitive flag |
| store_eoi_en | input | N_SRC | Per-source management-store enable |
| pq_chk_dis | input | N_SRC | Per-source coalescing disable |
| mmio_valid | input | 1 | Window access request |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | SRC_W+PAGE_SHIFT | Byte address within the window |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Previous state in bits [1:0] |
| trig_valid | input | 1 | Hardware trigger request |
| trig_src | input | SRC_W | Hardware trigger source number |
| trig_level | input | 1 | Line level for level sources; 1 = event |
| trig_ready | output | 1 | Hardware trigger accepted this cycle |
| notify_valid | output | 1 | Notification pulse |
| notify_src | output | SRC_W | Source being notified |

## Verification
The state update, the load response and the notification all come from the same rising edge that accepts an access, so each is due exactly one cycle after it. `trig_ready` is combinational and is due in the same cycle. The bench drives each access on a falling edge and checks `trig_ready` 1 ns later. It then samples the response and notification outputs 2 ns after the following rising edge and compares them against its behavioural model on every one of those cycles. Each "ignored" case is confirmed by a read on a later cycle, which returns the unchanged state.

// File: rtl/pqe_pkg.sv
package pqe_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_ASSERT,
        OP_DEASSERT,
        OP_EOI,
        OP_READ,
        OP_FORCE
    } pq_op_t;

    // management offset field addr[11:10]
    localparam logic [1:0] FLD_EOI   = 2'b00;
    localparam logic [1:0] FLD_STEOI = 2'b01;
    localparam logic [1:0] FLD_RW    = 2'b10;
    localparam logic [1:0] FLD_FORCE = 2'b11;

endpackage

// File: rtl/pqe_decode.sv
module pqe_decode
    import pqe_pkg::*;
#(
    parameter int N_SRC      = 16,
    parameter int PAGE_SHIFT = 13,
    parameter int SRC_W      = 4,
    parameter int ADDR_W     = 17
) (
    input  logic              mmio_valid,
    input  logic              mmio_write,
    input  logic [ADDR_W-1:0] mmio_addr,
    input  logic              trig_valid,
    input  logic [SRC_W-1:0]  trig_src,
    input  logic              trig_level,
    input  logic [N_SRC-1:0]  store_eoi_en,
    output pq_op_t            op,
    output logic [SRC_W-1:0]  op_src,
    output logic              src_ok,
    output pq_state_t         force_val,
    output logic              want_rsp
);
    localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

    logic [SRC_W-1:0] page_src;
    logic             mgmt_view;
    logic [1:0]       fld;

    assign page_src  = mmio_addr[ADDR_W-1:PAGE_SHIFT];
    assign fld       = mmio_addr[11:10];
    assign force_val = pq_state_t'(mmio_addr[9:8]);

    generate
        if (TWO_PAGE) begin : g_split
            assign mgmt_view = mmio_addr[PAGE_SHIFT-1];
        end else begin : g_shared
            assign mgmt_view = 1'b1;
        end
    endgenerate

    always_comb begin
        op       = OP_NONE;
        op_src   = trig_src;
        src_ok   = 1'b0;
        want_rsp = 1'b0;
        if (mmio_valid) begin
            op_src   = page_src;
            src_ok   = (32'(page_src) < N_SRC);
            want_rsp = !mmio_write;
            if (src_ok) begin
                if (!mmio_write) begin
                    if (!mgmt_view) begin
                        op = OP_READ;
                    end else begin
                        unique case (fld)
                            FLD_EOI:   op = OP_EOI;
                            FLD_STEOI: op = OP_READ;
                            FLD_RW:    op = OP_READ;
                            FLD_FORCE: op = OP_FORCE;
                        endcase
                    end
                end else if (!mgmt_view) begin
                    op = OP_TRIG;
                end else if (store_eoi_en[page_src]) begin
                    unique case (fld)
                        FLD_STEOI: op = OP_EOI;
                        FLD_RW:    op = OP_TRIG;
                        default:   op = OP_NONE;
                    endcase
                end
            end
        end else if (trig_valid) begin
            src_ok = (32'(trig_src) < N_SRC);
            if (src_ok) op = trig_level ? OP_ASSERT : OP_DEASSERT;
        end
    end

endmodule

// File: rtl/pqe_cell.sv
module pqe_cell
    import pqe_pkg::*;
#(
    parameter logic [1:0] RESET_PQ = 2'b00
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  pq_op_t    op,
    input  pq_state_t force_val,
    input  logic      is_lvl,
    input  logic      chk_dis,
    output pq_state_t pq,
    output logic      fwd
);
    pq_state_t nxt;
    logic      asserted, nxt_as;
    pq_state_t after_eoi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq       <= pq_state_t'(RESET_PQ);
            asserted <= 1'b0;
        end else begin
            pq       <= nxt;
            asserted <= nxt_as;
        end
    end

    // end-of-interrupt step before the level re-arm
    always_comb begin
        unique case (pq)
            PQ_PEND:   after_eoi = PQ_IDLE;
            PQ_OFF:    after_eoi = PQ_IDLE;
            PQ_QUEUED: after_eoi = PQ_PEND;
            PQ_IDLE:   after_eoi = PQ_IDLE;
        endcase
    end

    always_comb begin
        nxt    = pq;
        nxt_as = asserted;
        fwd    = 1'b0;
        if (sel) begin
            unique case (op)
                OP_TRIG, OP_ASSERT: begin
                    if (op == OP_ASSERT && is_lvl) nxt_as = 1'b1;
                    if (op == OP_TRIG || is_lvl || op == OP_ASSERT) begin
                        if (chk_dis) begin
                            fwd = 1'b1;
                        end else begin
                            unique case (pq)
                                PQ_IDLE:   begin nxt = PQ_PEND; fwd = 1'b1; end
                                PQ_PEND:   nxt = PQ_QUEUED;
                                PQ_QUEUED: nxt = PQ_QUEUED;
                                PQ_OFF:    nxt = PQ_OFF;
                            endcase
                        end
                    end
                end
                OP_DEASSERT: begin
                    if (is_lvl) nxt_as = 1'b0;
                end
                OP_EOI: begin
                    nxt = after_eoi;
                    fwd = (pq == PQ_QUEUED);
                    if (is_lvl && asserted && after_eoi == PQ_IDLE) begin
                        nxt = PQ_PEND;
                        fwd = 1'b1;
                    end
                end
                OP_FORCE: nxt = force_val;
                default: ;
            endcase
        end
    end

    assert_off_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_TRIG && !chk_dis && pq == PQ_OFF) |=> (pq == PQ_OFF));

    assert_queued_eoi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_EOI && pq == PQ_QUEUED) |=> (pq == PQ_PEND));

    assert_force_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_FORCE) |=> (pq == $past(force_val)));

    assert_nochk_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_TRIG && chk_dis) |=> $stable(pq));

endmodule

// File: rtl/pqe_bank.sv
module pqe_bank
    import pqe_pkg::*;
#(
    parameter int         N_SRC      = 16,
    parameter int         PAGE_SHIFT = 13,
    parameter int         DATA_W     = 64,
    parameter logic [1:0] RESET_PQ   = 2'b00,
    localparam int        SRC_W      = $clog2(N_SRC),
    localparam int        ADDR_W     = SRC_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  lvl_map,
    input  logic [N_SRC-1:0]  store_eoi_en,
    input  logic [N_SRC-1:0]  pq_chk_dis,
    input  logic              mmio_valid,
    input  logic              mmio_write,
    input  logic [ADDR_W-1:0] mmio_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              trig_valid,
    input  logic [SRC_W-1:0]  trig_src,
    input  logic              trig_level,
    output logic              trig_ready,
    output logic              notify_valid,
    output logic [SRC_W-1:0]  notify_src
);
    pq_op_t           op;
    logic [SRC_W-1:0] op_src;
    logic             src_ok;
    pq_state_t        force_val;
    logic             want_rsp;
    pq_state_t        pq_arr [N_SRC];
    logic [N_SRC-1:0] fwd_vec;

    assign trig_ready = !mmio_valid;

    pqe_decode #(
        .N_SRC(N_SRC), .PAGE_SHIFT(PAGE_SHIFT), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
    ) i_decode (
        .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr),
        .trig_valid(trig_valid), .trig_src(trig_src), .trig_level(trig_level),
        .store_eoi_en(store_eoi_en), .op(op), .op_src(op_src), .src_ok(src_ok),
        .force_val(force_val), .want_rsp(want_rsp)
    );

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            logic hit;
            assign hit = src_ok && (op != OP_NONE) && (op_src == SRC_W'(i));
            pqe_cell #(.RESET_PQ(RESET_PQ)) i_cell (
                .clk(clk), .rst_n(rst_n), .sel(hit), .op(op),
                .force_val(force_val), .is_lvl(lvl_map[i]),
                .chk_dis(pq_chk_dis[i]), .pq(pq_arr[i]), .fwd(fwd_vec[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            notify_valid <= 1'b0;
            notify_src   <= '0;
        end else begin
            rsp_valid    <= want_rsp;
            rsp_data     <= (want_rsp && src_ok) ?
                            {{(DATA_W-2){1'b0}}, pq_arr[op_src]} : '0;
            notify_valid <= |fwd_vec;
            notify_src   <= op_src;
        end
    end

    assert_rsp_from_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mmio_valid && !mmio_write));

    assert_notify_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(mmio_valid || trig_valid));

    assert_single_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_vec));

    assert_store_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_valid && mmio_write) |=> !rsp_valid);

endmodule

// File: tb/test_pqe_bank.sv
module test_pqe_bank;
    localparam int N = 16;
    localparam int SH = 13;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] lvl_map = 16'h00F0, seoi = 16'hFDFF, chk = 16'h0100;
    logic mmio_valid = 0, mmio_write = 0;
    logic [16:0] mmio_addr = '0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic trig_valid = 0, trig_level = 0;
    logic [3:0] trig_src = '0;
    logic trig_ready, notify_valid;
    logic [3:0] notify_src;

    int vectors = 0, fails = 0;
    int m_pq[N];
    bit m_as[N];
    bit exp_rv, exp_nv;
    int exp_rd, exp_ns;

    always #4 clk = ~clk;

    pqe_bank i_pqe_bank (
        .clk(clk), .rst_n(rst_n), .lvl_map(lvl_map), .store_eoi_en(seoi),
        .pq_chk_dis(chk), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
        .mmio_addr(mmio_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .trig_valid(trig_valid), .trig_src(trig_src), .trig_level(trig_level),
        .trig_ready(trig_ready), .notify_valid(notify_valid), .notify_src(notify_src)
    );

    task automatic m_trig(int s);
        if (chk[s]) begin exp_nv = 1; exp_ns = s; end
        else case (m_pq[s])
            0: begin m_pq[s] = 2; exp_nv = 1; exp_ns = s; end
            2: m_pq[s] = 3;
            default: ;
        endcase
    endtask

    task automatic m_eoi(int s);
        case (m_pq[s])
            3: begin m_pq[s] = 2; exp_nv = 1; exp_ns = s; end
            default: m_pq[s] = 0;
        endcase
        if (lvl_map[s] && m_as[s] && m_pq[s] == 0) begin
            m_pq[s] = 2; exp_nv = 1; exp_ns = s;
        end
    endtask

    task automatic compare(string tag);
        vectors++;
        if (rsp_valid !== exp_rv || (exp_rv && rsp_data !== 64'(exp_rd)) ||
            notify_valid !== exp_nv || (exp_nv && notify_src !== 4'(exp_ns))) begin
            fails++;
            $display("FAIL %s: rsp %0b/%0h notify %0b/%0d expected rsp %0b/%0h notify %0b/%0d",
                     tag, rsp_valid, rsp_data, notify_valid, notify_src,
                     exp_rv, exp_rd, exp_nv, exp_ns);
        end
    endtask

    task automatic check_ready(bit exp, string tag);
        vectors++;
        if (trig_ready !== exp) begin
            fails++;
            $display("FAIL %s: trig_ready %0b expected %0b", tag, trig_ready, exp);
        end
    endtask

    // stray: also offer a hardware trigger in the same cycle
    task automatic mmio(bit wr, int s, bit mgmt, int off, bit stray, string tag);
        @(negedge clk);
        mmio_valid = 1; mmio_write = wr;
        mmio_addr = 17'((s << SH) | (int'(mgmt) << (SH - 1)) | off);
        trig_valid = stray; trig_src = 4'(s); trig_level = 1;
        exp_rv = !wr; exp_rd = 0; exp_nv = 0; exp_ns = s;
        if (!wr) begin
            exp_rd = m_pq[s];
            if (mgmt) case ((off >> 10) & 3)
                0: m_eoi(s);
                3: m_pq[s] = (off >> 8) & 3;
                default: ;
            endcase
        end else if (!mgmt) begin
            m_trig(s);
        end else if (seoi[s]) begin
            case ((off >> 10) & 3)
                1: m_eoi(s);
                2: m_trig(s);
                default: ;
            endcase
        end
        #1 check_ready(0, "R7");
        @(posedge clk); #2;
        mmio_valid = 0; trig_valid = 0;
        compare(tag);
    endtask

    task automatic hw(int s, bit lvl, string tag);
        @(negedge clk);
        trig_valid = 1; trig_src = 4'(s); trig_level = lvl;
        exp_rv = 0; exp_rd = 0; exp_nv = 0; exp_ns = s;
        if (lvl_map[s]) m_as[s] = lvl;
        if (lvl) m_trig(s);
        #1 check_ready(1, "R7");
        @(posedge clk); #2;
        trig_valid = 0;
        compare(tag);
    endtask

    task automatic get(int s, string tag);
        mmio(0, s, 1, 'h800, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_pq[i] = 0; m_as[i] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        exp_rv = 0; exp_nv = 0; exp_rd = 0; exp_ns = 0;
        @(negedge clk); compare("R1"); check_ready(1, "R1");
        for (int i = 0; i < N; i++) get(i, "R1");
        // R2 trigger transitions, R10 notification
        hw(0, 1, "R2"); hw(0, 1, "R2"); hw(0, 1, "R2"); get(0, "R2");
        // R3 / R4 load EOI
        mmio(0, 0, 1, 'h000, 0, "R3"); mmio(0, 0, 1, 'h000, 0, "R3");
        mmio(0, 0, 1, 'h000, 0, "R3");
        // R4 forces and off state
        mmio(0, 1, 1, 'hD00, 0, "R4"); hw(1, 1, "R2"); get(1, "R4");
        mmio(0, 1, 1, 'h000, 0, "R3");
        mmio(0, 1, 1, 'hE00, 0, "R4"); mmio(0, 1, 1, 'hF00, 0, "R4");
        mmio(0, 1, 1, 'hC00, 0, "R4"); mmio(0, 1, 1, 'h400, 0, "R4");
        get(1, "R4");
        // R6 trigger page store, R5 store EOI
        mmio(1, 2, 0, 'h000, 0, "R6"); mmio(1, 2, 1, 'h400, 0, "R5");
        get(2, "R5");
        // R5 store gating on source 9
        hw(9, 1, "R2"); mmio(1, 9, 1, 'h400, 0, "R5"); get(9, "R5");
        mmio(1, 9, 1, 'h800, 0, "R5"); get(9, "R5");
        mmio(1, 9, 0, 'h000, 0, "R6"); get(9, "R6");
        // R5 inject, R6 trigger-page load
        mmio(1, 3, 1, 'h800, 0, "R5"); mmio(0, 3, 0, 'hC00, 0, "R6");
        get(3, "R6");
        // R8 coalescing disabled
        hw(8, 1, "R8"); hw(8, 1, "R8"); mmio(1, 8, 0, 0, 0, "R8"); get(8, "R8");
        // R9 level sources
        hw(4, 1, "R9"); mmio(0, 4, 1, 'h000, 0, "R9"); hw(4, 0, "R9");
        mmio(0, 4, 1, 'h000, 0, "R9"); get(4, "R9");
        hw(5, 1, "R9"); hw(5, 1, "R9"); mmio(0, 5, 1, 'h000, 0, "R9");
        hw(10, 0, "R9"); get(10, "R9");
        // R7 trigger ignored during a window access
        mmio(0, 11, 1, 'h800, 1, "R7"); get(11, "R7");
        // R10 idle cycle
        exp_rv = 0; exp_nv = 0;
        @(negedge clk); @(posedge clk); #2 compare("R10");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule